// File: doc/BRIEF.md
# Prescaled Line-Rate Interrupt Timer

This block raises an interrupt after a programmable number of display lines have passed. It counts only in CPU cycles that a cycle strobe marks. Each strobed cycle adds three units to a prescaler. When the prescaler holds 341 units or more, it gives one tick, which is about one display line. An 8-bit up-counter counts these ticks. When the counter wraps past its all-ones value, it raises an interrupt request and loads itself again from a reload latch. The request stays high until software acknowledges it.

Software programs the timer through three write-only registers on the CPU write bus:

| Address | Effect |
|---|---|
| 0xF000 | Loads the low nibble of the reload latch. |
| 0xF004 | Loads the high nibble of the reload latch. |
| 0xF008 | Copies the latch into the counter, clears the prescaler and sets the enable. |

A write to any of these three addresses also acknowledges a pending interrupt.

Top module: `line_irq_timer`

## Requirements
- R1: After reset, `irq` is low, the latch, counter and prescaler are zero, and counting is disabled. An enable-only control write therefore gives the first interrupt on the 29099th strobed cycle (256 ticks).
- R2: A write to 0xF000 loads latch bits [3:0] from `wr_data[3:0]`. Data bits [7:4] are ignored.
- R3: A write to 0xF004 loads latch bits [7:4] from `wr_data[3:0]`. Data bits [7:4] are ignored.
- R4: A write to 0xF008 copies the latch into the counter and sets the prescaler to zero. It also sets the enable from `wr_data` bit 1. No tick occurs in that cycle.
- R5: While enabled, each cycle with `cpu_ce` high adds 3 to the prescaler. When the sum reaches 341 or more, 341 is subtracted and one tick is issued. Tick n therefore lands on strobed cycle ceil(341·n/3); tick 1 lands on cycle 114.
- R6: Each tick increments the counter. A tick that takes the counter from 0xFF to 0x100 sets `irq` after that clock edge and reloads the counter from the latch. A latch value L therefore interrupts after 256−L ticks.
- R7: While disabled, or in cycles with `cpu_ce` low, neither the prescaler nor the counter changes.
- R8: A write to 0xF000, 0xF004 or 0xF008 clears `irq` after that edge. If an overflow happens in the same cycle, the overflow wins and `irq` stays high.
- R9: `irq` stays high through any number of further overflows until a write acknowledges it.
- R10: A latch write does not change the running counter. The new value takes effect at the next overflow reload or the next control write.
- R11: Writes to any other address, such as 0xF00C, change no state and do not acknowledge the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_ce | input | 1 | CPU cycle strobe; the timer counts only in cycles where it is high |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| irq | output | 1 | Active-high interrupt request |

## Verification
The assertions check these rules on every cycle:
- the prescaler and counter hold when they are not advanced (R7);
- a control write clears the prescaler and loads the counter (R4);
- an overflow reloads the counter and sets the request (R6);
- an acknowledge clears the request, and nothing else does (R8, R9).

Only the bench scenarios can show the end-to-end timing, because it depends on the whole accumulation history:
- the exact strobed cycle of each interrupt for different latch values (R5, R6);
- that a latch rewrite during counting is deferred (R10);
- that the ignored data bits and foreign addresses have no effect (R2, R3, R11).

// File: rtl/line_irq_pkg.sv
package line_irq_pkg;
   localparam int NIB_W = 4;
   typedef logic [NIB_W-1:0] nib_t;
endpackage

// File: rtl/line_irq_regs.sv
module line_irq_regs
   import line_irq_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 8,
   parameter int CNT_W      = 8,
   parameter int REG_BASE   = 'hF000,
   parameter int REG_STRIDE = 4,
   parameter int EN_BIT     = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [CNT_W-1:0]  latch_o,
   output logic              en_o,
   output logic              load_o,
   output logic              ack_o
);
   localparam int NIBS = CNT_W / NIB_W;
   localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(REG_BASE + NIBS * REG_STRIDE);

   initial begin
      assert (CNT_W % NIB_W == 0) else $error("CNT_W must be a multiple of 4");
      assert (EN_BIT < DATA_W) else $error("EN_BIT outside data bus");
   end

   logic [NIBS-1:0] nib_hit;
   logic            unused_data;
   logic            en_q;

   assign unused_data = ^wr_data;

   for (genvar i = 0; i < NIBS; i++) begin : g_nib
      localparam logic [ADDR_W-1:0] NIB_ADDR = ADDR_W'(REG_BASE + i * REG_STRIDE);
      nib_t nib_q;
      assign nib_hit[i] = wr_en && (wr_addr == NIB_ADDR);
      always_ff @(posedge clk) begin
         if (!rst_n)          nib_q <= '0;
         else if (nib_hit[i]) nib_q <= wr_data[NIB_W-1:0];
      end
      assign latch_o[i*NIB_W +: NIB_W] = nib_q;
   end

   assign load_o = wr_en && (wr_addr == CTRL_ADDR);
   assign ack_o  = load_o || (|nib_hit);

   always_ff @(posedge clk) begin
      if (!rst_n)      en_q <= 1'b0;
      else if (load_o) en_q <= wr_data[EN_BIT];
   end
   assign en_o = en_q;
endmodule

// File: rtl/line_prescale.sv
module line_prescale #(
   parameter int STEP   = 3,
   parameter int PERIOD = 341
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic adv_i,
   output logic tick_o
);
   localparam int PS_W = $clog2(PERIOD + STEP);
   localparam logic [PS_W-1:0] STEP_V = PS_W'(STEP);
   localparam logic [PS_W-1:0] PER_V  = PS_W'(PERIOD);

   initial begin
      assert (STEP > 0 && STEP < PERIOD) else $error("STEP must lie in 1..PERIOD-1");
   end

   logic [PS_W-1:0] acc_q, sum;

   assign sum    = acc_q + STEP_V;
   assign tick_o = adv_i && !clr_i && (sum >= PER_V);

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) acc_q <= '0;
      else if (adv_i)      acc_q <= tick_o ? sum - PER_V : sum;
   end

   // R7
   prsc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv_i && !clr_i) |=> $stable(acc_q));
   // R4
   prsc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (acc_q == '0));
   // R5
   prsc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> (acc_q < PER_V));
endmodule

// File: rtl/line_tick_counter.sv
module line_tick_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] latch_i,
   input  logic             tick_i,
   output logic             ovf_o
);
   logic [CNT_W:0] cnt_q, inc;

   assign inc   = cnt_q + 1'b1;
   assign ovf_o = tick_i && !load_i && inc[CNT_W];

   always_ff @(posedge clk) begin
      if (!rst_n)                cnt_q <= '0;
      else if (load_i || ovf_o)  cnt_q <= {1'b0, latch_i};
      else if (tick_i)           cnt_q <= inc;
   end

   // R4
   cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (cnt_q == {1'b0, $past(latch_i)}));
   // R6
   cnt_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |=> (cnt_q == {1'b0, $past(latch_i)}));
   // R7
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/line_irq_timer.sv
module line_irq_timer #(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 8,
   parameter int CNT_W      = 8,
   parameter int STEP       = 3,
   parameter int PERIOD     = 341,
   parameter int REG_BASE   = 'hF000,
   parameter int REG_STRIDE = 4,
   parameter int EN_BIT     = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_ce,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              irq
);
   logic [CNT_W-1:0] latch;
   logic en, load, ack, tick, ovf, irq_q;

   line_irq_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
      .REG_BASE(REG_BASE), .REG_STRIDE(REG_STRIDE), .EN_BIT(EN_BIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .latch_o(latch), .en_o(en), .load_o(load), .ack_o(ack)
   );

   line_prescale #(.STEP(STEP), .PERIOD(PERIOD)) u_pre (
      .clk(clk), .rst_n(rst_n), .clr_i(load), .adv_i(en && cpu_ce), .tick_o(tick)
   );

   line_tick_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load_i(load), .latch_i(latch),
      .tick_i(tick), .ovf_o(ovf)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)   irq_q <= 1'b0;
      else if (ovf) irq_q <= 1'b1;
      else if (ack) irq_q <= 1'b0;
   end
   assign irq = irq_q;

   // R6
   irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> irq);
   // R8
   irq_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !ovf) |=> !irq);
   // R9
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !ack) |=> irq);
endmodule

// File: tb/line_irq_timer_test.sv
module line_irq_timer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_ce = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        irq;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   line_irq_timer uut (
      .clk(clk), .rst_n(rst_n), .cpu_ce(cpu_ce), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .irq(irq)
   );

   // {latch, strobed cycles until the interrupt}
   localparam logic [23:0] VECS [5] = '{
      {8'hFF, 16'd114}, {8'hFE, 16'd228}, {8'hF0, 16'd1819},
      {8'hC3, 16'd6934}, {8'h80, 16'd14550}
   };

   task automatic run(input int n);
      repeat (n) begin
         @(negedge clk); cpu_ce = 1'b1; wr_en = 1'b0;
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic ce);
      @(negedge clk); cpu_ce = ce; wr_en = 1'b1; wr_addr = a; wr_data = d;
   endtask

   task automatic chk(input logic exp, input string tag);
      @(negedge clk); cpu_ce = 1'b0; wr_en = 1'b0;
      checks++;
      if (irq !== exp) begin
         errors++;
         $display("FAIL %s irq=%0b expected %0b", tag, irq, exp);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk(1'b0, "R1 reset");
      // R1: latch resets to zero, so 256 ticks are needed
      wr(16'hF008, 8'h02, 1'b0);
      run(29098); chk(1'b0, "R1 before overflow");
      run(1);     chk(1'b1, "R1 overflow");

      // R2 R3 R5 R6 R8: table walk; the upper data nibble carries junk
      foreach (VECS[i]) begin
         wr(16'hF000, {4'hA, VECS[i][19:16]}, 1'b0);
         wr(16'hF004, {4'h5, VECS[i][23:20]}, 1'b0);
         wr(16'hF008, 8'h02, 1'b0);
         run(int'(VECS[i][15:0]) - 1); chk(1'b0, "R5 R6 table early");
         run(1);                       chk(1'b1, "R2 R3 R5 R6 table on time");
         wr(16'hF000, {4'h0, VECS[i][19:16]}, 1'b0);
         chk(1'b0, "R8 ack by low latch write");
      end

      // R7: disabled, nothing advances (latch is 0x80 now; set 0xFF)
      wr(16'hF000, 8'h0F, 1'b0);
      wr(16'hF004, 8'h0F, 1'b0);
      wr(16'hF008, 8'hFD, 1'b0);
      run(500); chk(1'b0, "R7 disabled");
      // R7: enabled but strobe low
      wr(16'hF008, 8'h02, 1'b0);
      repeat (300) chk(1'b0, "R7 strobe low");
      run(113); chk(1'b0, "R7 strobe low no progress");
      run(1);   chk(1'b1, "R7 first tick after idle");

      // R4: control write zeroes a partly filled prescaler
      wr(16'hF008, 8'h02, 1'b0);
      run(100);
      wr(16'hF008, 8'h02, 1'b0);
      run(113); chk(1'b0, "R4 prescaler cleared");
      run(1);   chk(1'b1, "R4 tick after clear");

      // R9: sticky through further overflows
      run(300); chk(1'b1, "R9 sticky");
      // R11: foreign address does not acknowledge
      wr(16'hF00C, 8'hFF, 1'b0); chk(1'b1, "R11 foreign write");
      wr(16'hE008, 8'h00, 1'b0); chk(1'b1, "R11 foreign control");
      // R8: high nibble write acknowledges
      wr(16'hF004, 8'h0F, 1'b0); chk(1'b0, "R8 ack by high latch write");

      // R8: overflow wins over a same-cycle acknowledge
      wr(16'hF008, 8'h02, 1'b0);
      run(114); chk(1'b1, "R8 first overflow");
      run(113);
      wr(16'hF000, 8'h0F, 1'b1); chk(1'b1, "R8 overflow beats ack");
      wr(16'hF008, 8'h00, 1'b0); chk(1'b0, "R8 ack by control write");

      // R10: latch rewrite does not touch the running counter
      wr(16'hF008, 8'h02, 1'b0);
      wr(16'hF000, 8'h00, 1'b0);
      wr(16'hF004, 8'h00, 1'b0);
      run(113); chk(1'b0, "R10 early");
      run(1);   chk(1'b1, "R10 old count overflows");
      wr(16'hF000, 8'h00, 1'b0);
      run(29098); chk(1'b0, "R10 new latch early");
      run(1);     chk(1'b1, "R10 new latch on reload");

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(1900000 * 1ns);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog irq=%0b expected finish", irq);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule